// File: doc/BRIEF.md
# Clock Output Divider and Gate

This block produces the clock that leaves the chip on an output pad. It picks one of two running clocks, either a synthesized clock or the raw reference oscillator clock. It divides that clock by a power of two from 1 to 128. The result is a clean clock with equal high and low phases. A single control pin can then either tri-state the pad or stop the clock and ask upstream logic to power down.

A static configuration word sets the source, the divide ratio, the meaning of the control pin and its timing. In immediate mode the pin acts combinationally on the outputs. In clocked mode the pin first crosses into the output clock domain through a register chain. A stop is then deferred until the output is low, so no high phase is ever cut short. After a stop the divider restarts from the start of a high phase, which makes the first pulse full width.

Top module: `clkout_gate_ctrl`

## Requirements
- R1: The configuration inputs are captured on rising edges of `clk_ref` only while `rst_n` is low. Changing them after reset has no effect on any output.
- R2: `cfg_src_sel` = 0 selects `clk_syn` as the source clock and 1 selects `clk_ref`. All sequencing counts rising edges of the selected source.
- R3: For `cfg_div_sel` = k with 1 <= k <= 7, `clk_out` has a period of 2^k source cycles, with 2^(k-1) cycles high and 2^(k-1) low. On every start it goes high at the source rising edge that acts on the start request.
- R4: For `cfg_div_sel` = 0, `clk_out` is the source clock ANDed with an enable. In clocked mode that enable is updated only on falling source edges.
- R5: With `cfg_pin_mode` = 0, `ctl_in` high requests a running output. When stopped, `clk_oe` is low (pad in high impedance) and `clk_out` is low. `pd_req` stays low.
- R6: With `cfg_pin_mode` = 1, `ctl_in` high requests power-down. `clk_oe` stays high, `clk_out` is driven low once stopped, and `pd_req` is high while `ctl_in` is high and the output is stopped.
- R7: With `cfg_sync` = 0, `ctl_in` gates `clk_out` and `clk_oe` combinationally, and `pd_req` equals `ctl_in` in power-down mode.
- R8: With `cfg_sync` = 1, `ctl_in` passes through two source-clock register stages before it acts. A stop request arriving while `clk_out` is low takes effect at the next source edge. One arriving while `clk_out` is high waits for the edge that ends the high phase, so each high phase is full width.
- R9: While `rst_n` is low, `clk_out` is low and the output counts as stopped. `clk_oe` is then low in output-enable mode and high in power-down mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_syn | input | 1 | Synthesized clock, source 0 |
| clk_ref | input | 1 | Reference oscillator clock, source 1; also captures the configuration |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_src_sel | input | 1 | Source choice: 0 synthesized, 1 reference |
| cfg_div_sel | input | 3 | Divide exponent k, ratio 2^k |
| cfg_pin_mode | input | 1 | Control pin meaning: 0 output enable, 1 power-down |
| cfg_sync | input | 1 | 1 clocked, glitch-free control; 0 immediate control |
| ctl_in | input | 1 | Control pin |
| clk_out | output | 1 | Output clock toward the pad |
| clk_oe | output | 1 | Pad drive enable; low means high impedance |
| pd_req | output | 1 | Power-down request toward upstream clock logic |

## Verification
The assertions assume that the selected source clock keeps running and that the configuration is held steady for several reference edges while reset is low. They also assume that `ctl_in` never moves on a source clock edge, so the synchronizer chain sees clean values. The bench changes `ctl_in` one nanosecond after each source rising edge. It releases reset just after a source edge at a time that no reference edge shares, and it samples outputs once in each clock phase. A behavioural phase-position model then predicts the outputs.

// File: rtl/clkout_pkg.sv
`timescale 1ns/1ps
package clkout_pkg;

   typedef enum logic {
      SRC_SYNTH = 1'b0,
      SRC_REF   = 1'b1
   } src_sel_e;

   typedef enum logic {
      PIN_ENABLE    = 1'b0,
      PIN_POWERDOWN = 1'b1
   } pin_mode_e;

   typedef struct packed {
      src_sel_e  src;
      pin_mode_e pin_mode;
      logic      sync_mode;
   } cfg_t;

endpackage

// File: rtl/clkout_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer into the output clock domain.
module clkout_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("clkout_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= {STAGES{RST_VAL}};
      end else begin
         chain <= {chain[STAGES-2:0], d};
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/clkout_divider.sv
`timescale 1ns/1ps
// Power-of-two toggle divider with start and (optionally deferred) stop.
module clkout_divider #(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             graceful,
   input  logic [CNT_W-1:0] half_m1,
   output logic             active,
   output logic             phase
);

   logic [CNT_W-1:0] cnt;
   logic             wrap;
   logic             stop_now;

   assign wrap     = (cnt == half_m1);
   // A deferred stop waits until the phase is low or about to fall.
   assign stop_now = !run && (!graceful || !phase || wrap);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         phase  <= 1'b0;
         cnt    <= '0;
      end else if (!active) begin
         if (run) begin
            active <= 1'b1;
            phase  <= 1'b1;
            cnt    <= '0;
         end
      end else if (stop_now) begin
         active <= 1'b0;
         phase  <= 1'b0;
         cnt    <= '0;
      end else if (wrap) begin
         cnt    <= '0;
         phase  <= ~phase;
      end else begin
         cnt    <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/clkout_bypass_gate.sv
`timescale 1ns/1ps
// Enable for the undivided path, moved only while the clock is low.
module clkout_bypass_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic gate
);

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate <= 1'b0;
      end else begin
         gate <= run;
      end
   end

endmodule

// File: rtl/clkout_gate_ctrl.sv
`timescale 1ns/1ps
module clkout_gate_ctrl
   import clkout_pkg::*;
#(
   parameter  int MAX_DIV_LOG2 = 7,
   parameter  int SYNC_STAGES  = 2,
   localparam int DIV_SEL_W    = $clog2(MAX_DIV_LOG2 + 1),
   localparam int CNT_W        = (MAX_DIV_LOG2 > 1) ? MAX_DIV_LOG2 - 1 : 1
) (
   input  logic                 clk_syn,
   input  logic                 clk_ref,
   input  logic                 rst_n,
   input  logic                 cfg_src_sel,
   input  logic [DIV_SEL_W-1:0] cfg_div_sel,
   input  logic                 cfg_pin_mode,
   input  logic                 cfg_sync,
   input  logic                 ctl_in,
   output logic                 clk_out,
   output logic                 clk_oe,
   output logic                 pd_req
);

   generate
      if (MAX_DIV_LOG2 < 1 || MAX_DIV_LOG2 > 16) begin : g_bad_ratio
         $error("clkout_gate_ctrl: MAX_DIV_LOG2 out of range 1..16");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("clkout_gate_ctrl: SYNC_STAGES must be at least 2");
      end
   endgenerate

   // Configuration capture: loaded only while reset is held.
   cfg_t                 cfg_q;
   logic [DIV_SEL_W-1:0] div_sel_q;

   always_ff @(posedge clk_ref) begin
      if (!rst_n) begin
         cfg_q.src       <= src_sel_e'(cfg_src_sel);
         cfg_q.pin_mode  <= pin_mode_e'(cfg_pin_mode);
         cfg_q.sync_mode <= cfg_sync;
         div_sel_q       <= (cfg_div_sel > DIV_SEL_W'(MAX_DIV_LOG2)) ?
                            DIV_SEL_W'(MAX_DIV_LOG2) : cfg_div_sel;
      end
   end

   // Source selection (static outside reset).
   logic src_clk;
   assign src_clk = (cfg_q.src == SRC_REF) ? clk_ref : clk_syn;

   // Ratio decode.
   logic             bypass;
   logic [CNT_W:0]   half_full;
   logic [CNT_W-1:0] half_m1;

   assign bypass = (div_sel_q == '0);

   always_comb begin
      half_full = '0;
      half_m1   = '0;
      if (!bypass) begin
         half_full = {{CNT_W{1'b0}}, 1'b1} << (div_sel_q - 1'b1);
         half_m1   = CNT_W'(half_full - 1'b1);
      end
   end

   // Control decode: run_raw high means the output should run.
   logic pd_mode;
   logic run_raw;
   logic run_sync;
   logic run_sel;

   assign pd_mode = (cfg_q.pin_mode == PIN_POWERDOWN);
   assign run_raw = pd_mode ? ~ctl_in : ctl_in;

   clkout_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b0)
   ) u_sync (
      .clk   (src_clk),
      .rst_n (rst_n),
      .d     (run_raw),
      .q     (run_sync)
   );

   assign run_sel = cfg_q.sync_mode ? run_sync : run_raw;

   // Divided path and undivided path.
   logic div_active;
   logic div_q;
   logic byp_gate;

   clkout_divider #(
      .CNT_W (CNT_W)
   ) u_div (
      .clk      (src_clk),
      .rst_n    (rst_n),
      .run      (run_sel & ~bypass),
      .graceful (cfg_q.sync_mode),
      .half_m1  (half_m1),
      .active   (div_active),
      .phase    (div_q)
   );

   clkout_bypass_gate u_byp (
      .clk   (src_clk),
      .rst_n (rst_n),
      .run   (run_sel & bypass),
      .gate  (byp_gate)
   );

   // Output stage.
   logic running;
   logic path_clk;
   logic out_int;

   always_comb begin
      if (cfg_q.sync_mode) begin
         running  = bypass ? byp_gate : div_active;
         path_clk = bypass ? (src_clk & byp_gate) : div_q;
         out_int  = path_clk;
      end else begin
         running  = run_raw;
         path_clk = bypass ? src_clk : div_q;
         out_int  = path_clk & run_raw;
      end
   end

   assign clk_out = rst_n & out_int;
   assign clk_oe  = pd_mode ? 1'b1 : (rst_n & running);
   assign pd_req  = pd_mode & ctl_in & ~(rst_n & running);

endmodule

// File: rtl/clkout_gate_ctrl_chk.sv
`timescale 1ns/1ps
module clkout_gate_ctrl_chk #(
   parameter int DIV_SEL_W = 3,
   parameter int CNT_W     = 6
) (
   input logic                 src_clk,
   input logic                 rst_n,
   input logic                 pd_mode,
   input logic                 sync_mode,
   input logic [DIV_SEL_W-1:0] div_sel_q,
   input logic                 ctl_in,
   input logic                 clk_out,
   input logic                 clk_oe,
   input logic                 pd_req
);

   logic [CNT_W+1:0] hi_cnt;
   logic [CNT_W+1:0] half_len;

   assign half_len = (div_sel_q == '0) ? (CNT_W+2)'(1) :
                     ((CNT_W+2)'(1) << (div_sel_q - 1'b1));

   // Length of the current high run of clk_out in source cycles.
   always_ff @(posedge src_clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_cnt <= '0;
      end else if (!clk_out) begin
         hi_cnt <= '0;
      end else if (hi_cnt != '1) begin
         hi_cnt <= hi_cnt + 1'b1;
      end
   end

   // R3 R8: clocked divided output never shortens a high phase.
   a_r3_full_high_phase: assert property (@(posedge src_clk) disable iff (!rst_n)
      (sync_mode && (div_sel_q != '0) && $fell(clk_out)) |-> (hi_cnt == half_len));

   // R5: pad disabled implies the clock is low.
   a_r5_off_pad_low: assert property (@(posedge src_clk) disable iff (!rst_n)
      !clk_oe |-> !clk_out);

   // R6: power-down mode keeps the pad driven.
   a_r6_pd_pad_on: assert property (@(posedge src_clk) disable iff (!rst_n)
      pd_mode |-> clk_oe);

   // R7: immediate power-down request follows the pin.
   a_r7_async_pd_follow: assert property (@(posedge src_clk) disable iff (!rst_n)
      (pd_mode && !sync_mode) |-> (pd_req == ctl_in));

   // R8: clocked power-down request rises only with the output low.
   a_r8_pd_after_stop: assert property (@(posedge src_clk) disable iff (!rst_n)
      (sync_mode && (div_sel_q != '0) && $rose(pd_req)) |-> !clk_out);

endmodule

bind clkout_gate_ctrl clkout_gate_ctrl_chk #(
   .DIV_SEL_W (DIV_SEL_W),
   .CNT_W     (CNT_W)
) i_chk (
   .src_clk   (src_clk),
   .rst_n     (rst_n),
   .pd_mode   (pd_mode),
   .sync_mode (cfg_q.sync_mode),
   .div_sel_q (div_sel_q),
   .ctl_in    (ctl_in),
   .clk_out   (clk_out),
   .clk_oe    (clk_oe),
   .pd_req    (pd_req)
);

// File: tb/test_clkout_gate_ctrl.sv
`timescale 1ns/1ps
module test_clkout_gate_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int REF_PERIOD = 14;
   localparam int WD_NS      = 1500000;

   logic       clk_syn = 1'b0;
   logic       clk_ref = 1'b0;
   logic       rst_n;
   logic       cfg_src_sel;
   logic [2:0] cfg_div_sel;
   logic       cfg_pin_mode;
   logic       cfg_sync;
   logic       ctl_in;
   logic       clk_out;
   logic       clk_oe;
   logic       pd_req;

   clkout_gate_ctrl i_clkout_gate_ctrl (
      .clk_syn      (clk_syn),
      .clk_ref      (clk_ref),
      .rst_n        (rst_n),
      .cfg_src_sel  (cfg_src_sel),
      .cfg_div_sel  (cfg_div_sel),
      .cfg_pin_mode (cfg_pin_mode),
      .cfg_sync     (cfg_sync),
      .ctl_in       (ctl_in),
      .clk_out      (clk_out),
      .clk_oe       (clk_oe),
      .pd_req       (pd_req)
   );

   always #(CLK_PERIOD/2) clk_syn = ~clk_syn;
   always #(REF_PERIOD/2) clk_ref = ~clk_ref;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   // Reference model state.
   int  m_k;
   bit  m_ref, m_pd, m_sync, m_r1;
   bit  m_s1, m_s2, m_gate, m_act;
   int  m_pos;
   bit  pin_q;
   logic [15:0] lfsr = 16'hACE1;

   task automatic check(input string tag, input string what, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic model_edge();
      bit raw, r;
      int h;
      raw = m_pd ? !pin_q : pin_q;
      r   = m_sync ? m_s2 : raw;
      m_gate = m_s2;
      m_s2   = m_s1;
      m_s1   = raw;
      if (m_k != 0) begin
         h = 1 << (m_k - 1);
         if (!m_act) begin
            if (r) begin
               m_act = 1;
               m_pos = 0;
            end
         end else if (!r && (!m_sync || m_pos >= h - 1)) begin
            m_act = 0;
         end else begin
            m_pos = (m_pos + 1) % (2 * h);
         end
      end
   endtask

   task automatic compare(input bit hi);
      bit raw_new, g, q_e, run_e, out_e, oe_e, pd_e;
      int h;
      string t_out, t_pin;
      h       = (m_k == 0) ? 1 : (1 << (m_k - 1));
      raw_new = m_pd ? !pin_q : pin_q;
      g       = hi ? m_gate : m_s2;
      q_e     = m_act && (m_pos < h);
      if (m_sync) begin
         run_e = (m_k == 0) ? g : m_act;
         out_e = (m_k == 0) ? (g && hi) : q_e;
      end else begin
         run_e = raw_new;
         out_e = raw_new && ((m_k == 0) ? hi : q_e);
      end
      oe_e = m_pd ? 1'b1 : run_e;
      pd_e = m_pd && pin_q && !run_e;
      t_out = (m_k == 0) ? "R4" : "R3";
      t_pin = m_pd ? "R6" : "R5";
      if (m_sync) begin
         t_out = {t_out, " R8"};
         t_pin = {t_pin, " R8"};
      end else begin
         t_out = {t_out, " R7"};
         t_pin = {t_pin, " R7"};
      end
      if (m_ref) t_out = {t_out, " R2"};
      if (m_r1) begin
         t_out = {t_out, " R1"};
         t_pin = {t_pin, " R1"};
      end
      check(t_out, "clk_out", clk_out, out_e);
      check(t_pin, "clk_oe", clk_oe, oe_e);
      check(t_pin, "pd_req", pd_req, pd_e);
   endtask

   task automatic cycle(input logic p);
      int hp;
      hp = m_ref ? REF_PERIOD/2 : CLK_PERIOD/2;
      if (m_ref) @(posedge clk_ref);
      else       @(posedge clk_syn);
      model_edge();
      #1;
      ctl_in = p;
      pin_q  = p;
      #2;
      compare(1'b1);
      #(hp - 1);
      compare(1'b0);
   endtask

   task automatic do_reset(input bit s_ref, input int k, input bit pd, input bit sy, input logic p);
      rst_n        = 1'b0;
      cfg_src_sel  = s_ref;
      cfg_div_sel  = 3'(k);
      cfg_pin_mode = pd;
      cfg_sync     = sy;
      ctl_in       = p;
      pin_q        = p;
      repeat (3) @(posedge clk_ref);
      #2;
      // R9: reset state
      check("R9", "clk_out in reset", clk_out, 1'b0);
      check("R9", "clk_oe in reset", clk_oe, pd);
      m_ref = s_ref; m_k = k; m_pd = pd; m_sync = sy; m_r1 = 0;
      m_s1 = 0; m_s2 = 0; m_gate = 0; m_act = 0; m_pos = 0;
      if (s_ref) @(posedge clk_ref);
      else       @(posedge clk_syn);
      #1;
      rst_n = 1'b1;
   endtask

   task automatic run_random(input int n, input int maxhold);
      int   hold;
      logic nxt;
      hold = 0;
      nxt  = pin_q;
      for (int i = 0; i < n; i++) begin
         if (hold == 0) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            nxt  = lfsr[0];
            hold = 1 + (int'(lfsr[15:4]) % maxhold);
         end
         hold--;
         cycle(nxt);
      end
   endtask

   initial begin
      #(WD_NS);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog all requirements actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; ctl_in = 1'b0; cfg_src_sel = 1'b0;
      cfg_div_sel = 3'd0; cfg_pin_mode = 1'b0; cfg_sync = 1'b0;

      // R3 R5 R8: synthesized source, divide by 4, enable pin, clocked
      do_reset(1'b0, 2, 1'b0, 1'b1, 1'b1);
      run_random(300, 12);
      // R4 R5 R8: undivided, enable pin, clocked
      do_reset(1'b0, 0, 1'b0, 1'b1, 1'b0);
      run_random(200, 6);
      // R2 R3 R6 R8: reference source, divide by 8, power-down, clocked
      do_reset(1'b1, 3, 1'b1, 1'b1, 1'b0);
      run_random(300, 20);
      // R3 R6 R7: divide by 2, power-down, immediate
      do_reset(1'b0, 1, 1'b1, 1'b0, 1'b0);
      run_random(200, 5);
      // R2 R4 R5 R7: reference source undivided, enable pin, immediate
      do_reset(1'b1, 0, 1'b0, 1'b0, 1'b1);
      run_random(150, 4);
      // R3 R8: largest ratio, divide by 128
      do_reset(1'b0, 7, 1'b0, 1'b1, 1'b1);
      run_random(1600, 600);
      // R2 R3 R6 R7: reference source, divide by 64, power-down, immediate
      do_reset(1'b1, 6, 1'b1, 1'b0, 1'b1);
      run_random(500, 200);
      // R1: configuration changes after reset must be ignored
      do_reset(1'b0, 5, 1'b1, 1'b1, 1'b0);
      cfg_src_sel  = 1'b1;
      cfg_div_sel  = 3'd1;
      cfg_pin_mode = 1'b0;
      cfg_sync     = 1'b0;
      m_r1 = 1;
      run_random(400, 40);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

endmodule